// File: doc/BRIEF.md
# ADC Link Liveness Range Checker

This block is a built-in self-test for a converter data link. After a start pulse it watches a stream of signed samples qualified by a valid strobe. It keeps a running minimum and maximum over a fixed window of valid samples. At the end of the window it decides whether the link is alive. The link counts as alive only when the spread between the largest and smallest sample is larger than a programmable threshold. A link that only delivers a constant value fails even though it keeps strobing valid. This covers an output stuck at zero, one stuck at either full-scale rail, and a dead lane whose data never changes.

Results are registered. They stay on the outputs until the next start pulse, so a slow controller can read them at any later time. A start pulse in the middle of a window drops the partial window and begins a new one.

Top module: `adc_range_check`

## Requirements
- R1: While rst_ni is low and after reset is released, done_o, pass_o and detail_o are all 0.
- R2: A start_i pulse clears done_o, pass_o and detail_o on the next clock edge and begins a fresh window. This holds even if an earlier window was only partly captured.
- R3: done_o rises on the clock edge that follows the edge which accepted the WINDOW-th valid sample after start (default WINDOW = 256). It is never high earlier.
- R4: pass_o is 1 exactly when max − min over the window is strictly greater than THRESHOLD (default 10). A spread equal to THRESHOLD fails and a spread of THRESHOLD+1 passes.
- R5: A window of constant 0 samples fails: done_o=1, pass_o=0, detail_o=8'hAD.
- R6: A window of constant 16'h7FFF samples, or of constant 16'h8000 samples, fails with detail_o=8'hAD.
- R7: A passing window (for example a ramp) gives detail_o=8'h00.
- R8: Once done_o is high, done_o, pass_o and detail_o do not change until the next start_i, whatever valid_i and sample_i do.
- R9: The spread is computed one bit wider than the sample. The full-swing pair −32768 and +32767 (spread 65535) therefore passes and does not wrap.
- R10: Cycles with valid_i low neither count toward the window nor change min and max, whatever value sample_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a new capture window; overrides everything else |
| valid_i | input | 1 | Qualifies sample_i |
| sample_i | input | SAMPLE_W | Signed two's complement sample |
| done_o | output | 1 | Verdict available, held until next start |
| pass_o | output | 1 | Spread exceeded threshold |
| detail_o | output | 8 | 8'h00 on pass, 8'hAD on fail, 0 while not done |

## Verification
The outputs clear one edge after the edge that captures start_i. The verdict lands one edge after the edge that accepted the last valid sample, because one judging cycle sits between them. The bench drives stimulus on falling edges and reads outputs on falling edges. Just after the last valid sample it checks that done_o is still low. One cycle later it checks done_o, pass_o and detail_o. After a start it checks for cleared outputs on the very next falling edge. For the hold property it samples the outputs on every falling edge across twenty cycles of extra stimulus after done.

// File: rtl/adc_rc_pkg.sv
package adc_rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_JUDGE   = 2'd2
  } rc_state_e;

  localparam logic [7:0] CODE_PASS = 8'h00;
  localparam logic [7:0] CODE_FAIL = 8'hAD;
endpackage

// File: rtl/adc_rc_window.sv
module adc_rc_window
  import adc_rc_pkg::*;
#(
  parameter int WINDOW = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  output logic sample_en_o,
  output logic judge_o
);
  localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  rc_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  assign sample_en_o = (state_q == ST_CAPTURE) && valid_i && !start_i;
  assign judge_o     = (state_q == ST_JUDGE) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_CAPTURE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_CAPTURE: if (valid_i) begin
          if (cnt_q == LAST) state_q <= ST_JUDGE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_JUDGE: state_q <= ST_IDLE;
        default:  state_q <= state_q;
      endcase
    end
  end
endmodule

// File: rtl/adc_rc_extrema.sv
module adc_rc_extrema #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       upd_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [SAMPLE_W-1:0] min_o,
  output logic signed [SAMPLE_W-1:0] max_o
);
  localparam logic signed [SAMPLE_W-1:0] POS_FULL = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] NEG_FULL = {1'b1, {(SAMPLE_W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_o <= POS_FULL;
      max_o <= NEG_FULL;
    end else if (clear_i) begin
      min_o <= POS_FULL;
      max_o <= NEG_FULL;
    end else if (upd_i) begin
      if (sample_i < min_o) min_o <= sample_i;
      if (sample_i > max_o) max_o <= sample_i;
    end
  end
endmodule

// File: rtl/adc_rc_verdict.sv
module adc_rc_verdict
  import adc_rc_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int THRESHOLD = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       judge_i,
  input  logic signed [SAMPLE_W-1:0] min_i,
  input  logic signed [SAMPLE_W-1:0] max_i,
  output logic                       done_o,
  output logic                       pass_o,
  output logic [7:0]                 detail_o
);
  localparam int DW = SAMPLE_W + 1;
  localparam logic signed [DW-1:0] TH_S = DW'(THRESHOLD);

  logic signed [DW-1:0] spread;
  logic                 above;

  // one extra bit: full-scale swing cannot wrap
  assign spread = {max_i[SAMPLE_W-1], max_i} - {min_i[SAMPLE_W-1], min_i};
  assign above  = spread > TH_S;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      pass_o   <= 1'b0;
      detail_o <= '0;
    end else if (clear_i) begin
      done_o   <= 1'b0;
      pass_o   <= 1'b0;
      detail_o <= '0;
    end else if (judge_i) begin
      done_o   <= 1'b1;
      pass_o   <= above;
      detail_o <= above ? CODE_PASS : CODE_FAIL;
    end
  end
endmodule

// File: rtl/adc_range_check.sv
module adc_range_check #(
  parameter int SAMPLE_W  = 16,
  parameter int WINDOW    = 256,
  parameter int THRESHOLD = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       done_o,
  output logic                       pass_o,
  output logic [7:0]                 detail_o
);
  logic                       sample_en, judge;
  logic signed [SAMPLE_W-1:0] min_w, max_w;

  adc_rc_window #(.WINDOW(WINDOW)) u_window (
    .clk_i, .rst_ni, .start_i, .valid_i,
    .sample_en_o(sample_en),
    .judge_o    (judge)
  );

  adc_rc_extrema #(.SAMPLE_W(SAMPLE_W)) u_extrema (
    .clk_i, .rst_ni,
    .clear_i (start_i),
    .upd_i   (sample_en),
    .sample_i,
    .min_o   (min_w),
    .max_o   (max_w)
  );

  adc_rc_verdict #(.SAMPLE_W(SAMPLE_W), .THRESHOLD(THRESHOLD)) u_verdict (
    .clk_i, .rst_ni,
    .clear_i (start_i),
    .judge_i (judge),
    .min_i   (min_w),
    .max_i   (max_w),
    .done_o, .pass_o, .detail_o
  );
endmodule

// File: rtl/adc_range_check_chk.sv
module adc_range_check_chk #(
  parameter int SAMPLE_W  = 16,
  parameter int WINDOW    = 256,
  parameter int THRESHOLD = 10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       start_i,
  input logic                       valid_i,
  input logic signed [SAMPLE_W-1:0] sample_i,
  input logic                       done_o,
  input logic                       pass_o,
  input logic [7:0]                 detail_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WINDOW);

  logic [CW-1:0]              seen_q;
  logic                       armed_q;
  logic signed [SAMPLE_W-1:0] lo_q, hi_q;
  logic signed [SAMPLE_W:0]   ref_spread;

  assign ref_spread = {hi_q[SAMPLE_W-1], hi_q} - {lo_q[SAMPLE_W-1], lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= '0;
      armed_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (start_i) begin
      seen_q  <= '0;
      armed_q <= 1'b1;
      lo_q    <= {1'b0, {(SAMPLE_W-1){1'b1}}};
      hi_q    <= {1'b1, {(SAMPLE_W-1){1'b0}}};
    end else if (armed_q && valid_i && seen_q < WIN_C) begin
      seen_q <= seen_q + 1'b1;
      if (sample_i < lo_q) lo_q <= sample_i;
      if (sample_i > hi_q) hi_q <= sample_i;
    end
  end

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !pass_o && detail_o == 8'h00));

  assert_done_at_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (armed_q && seen_q == WIN_C));

  assert_no_early_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q || seen_q < WIN_C) |-> !done_o);

  assert_verdict_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (pass_o == (ref_spread > (SAMPLE_W+1)'(THRESHOLD))));

  assert_pass_needs_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);

  assert_fail_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> detail_o == 8'hAD);

  assert_pass_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> detail_o == 8'h00);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(detail_o)));
endmodule

bind adc_range_check adc_range_check_chk #(
  .SAMPLE_W(SAMPLE_W), .WINDOW(WINDOW), .THRESHOLD(THRESHOLD)
) chk_i (
  .clk_i, .rst_ni, .start_i, .valid_i, .sample_i,
  .done_o, .pass_o, .detail_o
);

// File: tb/adc_range_check_tb_top.sv
`timescale 1ns/1ps
module adc_range_check_tb_top;
  localparam int SW = 16;
  localparam int WIN = 256;
  localparam int TH = 10;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic                 valid = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic                 done, pass;
  logic [7:0]           detail;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  adc_range_check #(.SAMPLE_W(SW), .WINDOW(WIN), .THRESHOLD(TH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid),
    .sample_i(sample), .done_o(done), .pass_o(pass), .detail_o(detail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic signed [SW-1:0] pat(input int kind, input int i);
    case (kind)
      0: return SW'(i * 100 - 12800);
      1: return '0;
      2: return 16'sh7FFF;
      3: return 16'sh8000;
      4: return (i % 2) ? 16'sd10 : 16'sd0;
      5: return (i % 2) ? 16'sd11 : 16'sd0;
      6: return (i % 2) ? 16'sh7FFF : 16'sh8000;
      default: return 16'sd5;
    endcase
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; valid = 1'b0;
    @(negedge clk); start = 1'b0;
    check(!done && !pass && detail == 8'h00, "R2", {done, pass, detail}, 0);
  endtask

  // full window; gaps inserts an invalid extreme sample before each valid one
  task automatic capture(input int kind, input bit gaps);
    pulse_start();
    for (int i = 0; i < WIN; i++) begin
      if (gaps) begin
        @(negedge clk); valid = 1'b0; sample = (i % 2) ? 16'sh7FFF : 16'sh8000;
      end
      @(negedge clk);
      if (i == WIN - 1) check(!done, "R3", done, 0);
      valid = 1'b1; sample = pat(kind, i);
    end
    @(negedge clk); valid = 1'b0;
    check(!done, "R3", done, 0);
    @(negedge clk);
    check(done, "R3", done, 1);
  endtask

  task automatic expect_result(input bit exp_pass, input string req);
    logic [7:0] code;
    code = exp_pass ? 8'h00 : 8'hAD;
    check(pass == exp_pass, req, pass, exp_pass);
    check(detail == code, req, detail, code);
  endtask

  task automatic t_reset();
    check(!done && !pass && detail == 8'h00, "R1", {done, pass, detail}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!done && !pass && detail == 8'h00, "R1", {done, pass, detail}, 0);
  endtask

  task automatic t_ramp();      capture(0, 0); expect_result(1, "R7"); endtask
  task automatic t_zero();      capture(1, 0); expect_result(0, "R5"); endtask
  task automatic t_rail_hi();   capture(2, 0); expect_result(0, "R6"); endtask
  task automatic t_rail_lo();   capture(3, 0); expect_result(0, "R6"); endtask
  task automatic t_edge_eq();   capture(4, 0); expect_result(0, "R4"); endtask
  task automatic t_edge_over(); capture(5, 0); expect_result(1, "R4"); endtask
  task automatic t_full();      capture(6, 0); expect_result(1, "R9"); endtask
  task automatic t_gaps();      capture(7, 1); expect_result(0, "R10"); endtask

  task automatic t_hold();
    capture(1, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); valid = 1'b1; sample = pat(0, i * 13);
      check(done && !pass && detail == 8'hAD, "R8", {done, pass, detail}, 10'h0AD | 10'h200);
    end
    @(negedge clk); valid = 1'b0;
    check(done && !pass && detail == 8'hAD, "R8", {done, pass, detail}, 10'h2AD);
  endtask

  task automatic t_restart();
    capture(0, 0);
    pulse_start();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); valid = 1'b1; sample = pat(0, i);
    end
    @(negedge clk); valid = 1'b0;
    check(!done, "R2", done, 0);
    capture(1, 0);
    expect_result(0, "R2");
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ramp();
    t_zero();
    t_rail_hi();
    t_rail_lo();
    t_edge_eq();
    t_edge_over();
    t_full();
    t_gaps();
    t_hold();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule